// File: doc/BRIEF.md
# Segmented Current-DAC Switch Decoder with Rotating Calibration Spare

This block turns a signed 16-bit audio sample into the switch settings of a segmented current-steering converter. The upper part of the code chooses how many of 32 equal unit sources feed the output. The lower 11 bits drive a binary current divider, and that divider is fed by one further unit source. There are 33 physical unit sources in all. At any moment one of them is taken out of service so that it can be recalibrated. The other 32 fill every active position, so conversion carries on without a gap.

Before the code is split, a fixed offset is added to it. This places the region around zero in the middle of a single coarse step, so a zero crossing moves only the divider bits and never switches a unit source. Every output is registered and changes only on a sample-update strobe. The calibration slot steps to the next physical source on a strobe after a set number of updates, and the new slot already applies to the outputs written on that same strobe.

Top module: `dac_seg_decoder`

## Requirements
- R1: While reset is low, and afterwards until the first strobe, src_en is all zero, cal_ptr is 0, div_ptr is 1 and div_sw is 0.
- R2: On a strobe the sample is mapped as u = code + 32768 + 1024 (code read as two's complement). The coarse count k is u[15:11] and div_sw takes u[10:0].
- R3: Every code from -1024 to +1023 gives k = 16. Stepping from -1 to 0 therefore changes only div_sw and leaves src_en and div_ptr unchanged.
- R4: The active positions 0..31 are assigned in ascending order to the physical sources other than cal_ptr. src_en has bit s set exactly when source s holds one of the positions 0..k-1.
- R5: div_ptr is the physical source that holds active position k. Its src_en bit is clear.
- R6: The source at cal_ptr is never enabled and is never equal to div_ptr.
- R7: src_en, cal_ptr, div_ptr and div_sw change only on the clock edge where sample_stb is high. The sample_code value between strobes has no effect on them.
- R8: cal_ptr advances by one on every ROT_DIV-th strobe (default 64) and wraps from 32 to 0.
- R9: On a strobe that advances cal_ptr, the src_en and div_ptr written on that same strobe already use the new cal_ptr.
- R10: Codes above +31743 saturate to k = 31 and div_sw = 2047. The code -32768 gives k = 0, so no source is enabled and div_sw = 1024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Sample-update strobe, one cycle per new sample |
| sample_code | input | 16 | Two's complement sample, taken when the strobe is high |
| src_en | output | 33 | Unit-source enables, one bit per physical source |
| cal_ptr | output | 6 | Physical source currently out of service for calibration |
| div_ptr | output | 6 | Physical source feeding the binary divider |
| div_sw | output | 11 | Binary divider bit switches |

## Verification
The checker assumes that a strobe is a single-cycle pulse and that sample_code is meaningful only while it is high. It also assumes reset is held for at least one clock edge, so every register begins from its defined value. The bench raises the strobe for exactly one cycle and changes sample_code to junk values between strobes, which tests that those values are ignored. It never strobes during reset, and it runs enough updates to take the calibration slot through all 33 sources and back to 0.

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
   // Default geometry of the segmented converter
   localparam int unsigned DEF_CODE_W  = 16;
   localparam int unsigned DEF_FINE_W  = 11;
   localparam int unsigned DEF_ROT_DIV = 64;
endpackage

// File: rtl/dac_seg_code_map.sv
// Symmetric offset mapping: signed code -> coarse count + fine divider word
module dac_seg_code_map #(
   parameter int unsigned CODE_W = dac_seg_pkg::DEF_CODE_W,
   parameter int unsigned FINE_W = dac_seg_pkg::DEF_FINE_W,
   localparam int unsigned COARSE_W = CODE_W - FINE_W
) (
   input  logic [CODE_W-1:0]   code,
   output logic [COARSE_W-1:0] coarse,
   output logic [FINE_W-1:0]   fine
);
   localparam logic [CODE_W:0] HALF_STEP = (CODE_W+1)'(1) << (FINE_W - 1);

   logic [CODE_W:0] biased;
   logic            sat;

   always_comb begin
      // offset binary (sign bit flipped) plus half a coarse step
      biased = {1'b0, ~code[CODE_W-1], code[CODE_W-2:0]} + HALF_STEP;
      sat    = biased[CODE_W];
      coarse = sat ? '1 : biased[CODE_W-1:FINE_W];
      fine   = sat ? '1 : biased[FINE_W-1:0];
   end
endmodule

// File: rtl/dac_seg_cal_rot.sv
// Calibration slot rotation: one step every ROT_DIV sample strobes
module dac_seg_cal_rot #(
   parameter int unsigned N_SRC   = 33,
   parameter int unsigned ROT_DIV = dac_seg_pkg::DEF_ROT_DIV,
   localparam int unsigned PTR_W  = $clog2(N_SRC),
   localparam int unsigned CNT_W  = (ROT_DIV > 1) ? $clog2(ROT_DIV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   output logic [PTR_W-1:0] cal_nxt
);
   logic [CNT_W-1:0] cnt_q;
   logic [PTR_W-1:0] cal_q;
   logic             wrap;

   always_comb begin
      wrap    = (cnt_q == CNT_W'(ROT_DIV - 1));
      cal_nxt = cal_q;
      if (stb && wrap)
         cal_nxt = (cal_q == PTR_W'(N_SRC - 1)) ? '0 : cal_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         cal_q <= '0;
      end else if (stb) begin
         cnt_q <= wrap ? '0 : cnt_q + 1'b1;
         cal_q <= cal_nxt;
      end
   end
endmodule

// File: rtl/dac_seg_router.sv
// Maps active positions onto physical sources, skipping the calibration slot
module dac_seg_router #(
   parameter int unsigned COARSE_W = 5,
   localparam int unsigned N_SRC   = (1 << COARSE_W) + 1,
   localparam int unsigned PTR_W   = $clog2(N_SRC)
) (
   input  logic [COARSE_W-1:0] coarse,
   input  logic [PTR_W-1:0]    cal,
   output logic [N_SRC-1:0]    en,
   output logic [PTR_W-1:0]    div_src
);
   logic [PTR_W-1:0] k_ext;

   assign k_ext   = PTR_W'(coarse);
   // position k sits on source k below the slot, on k+1 at or above it
   assign div_src = (k_ext < cal) ? k_ext : k_ext + 1'b1;

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      localparam logic [PTR_W-1:0] SI = PTR_W'(s);
      // below the slot position = s, above it position = s-1
      assign en[s] = (SI != cal) && ((SI < cal) ? (SI < k_ext) : (SI <= k_ext));
   end
endmodule

// File: rtl/dac_seg_decoder.sv
// Top: segmented DAC switch decoder with rotating calibration spare
module dac_seg_decoder #(
   parameter int unsigned CODE_W   = dac_seg_pkg::DEF_CODE_W,
   parameter int unsigned FINE_W   = dac_seg_pkg::DEF_FINE_W,
   parameter int unsigned ROT_DIV  = dac_seg_pkg::DEF_ROT_DIV,
   localparam int unsigned COARSE_W = CODE_W - FINE_W,
   localparam int unsigned N_SRC    = (1 << COARSE_W) + 1,
   localparam int unsigned PTR_W    = $clog2(N_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sample_stb,
   input  logic [CODE_W-1:0] sample_code,
   output logic [N_SRC-1:0]  src_en,
   output logic [PTR_W-1:0]  cal_ptr,
   output logic [PTR_W-1:0]  div_ptr,
   output logic [FINE_W-1:0] div_sw
);
   // elaboration-time parameter checks
   if (FINE_W < 1 || FINE_W >= CODE_W - 1) begin : g_bad_fine
      $error("dac_seg_decoder: FINE_W must leave at least two coarse bits");
   end
   if (COARSE_W > 8) begin : g_bad_coarse
      $error("dac_seg_decoder: coarse part too wide for a unit array");
   end
   if (ROT_DIV < 1) begin : g_bad_rot
      $error("dac_seg_decoder: ROT_DIV must be at least 1");
   end

   logic [COARSE_W-1:0] coarse_c;
   logic [FINE_W-1:0]   fine_c;
   logic [PTR_W-1:0]    cal_nxt;
   logic [N_SRC-1:0]    en_c;
   logic [PTR_W-1:0]    div_c;

   dac_seg_code_map #(.CODE_W(CODE_W), .FINE_W(FINE_W)) u_map (
      .code   (sample_code),
      .coarse (coarse_c),
      .fine   (fine_c)
   );

   dac_seg_cal_rot #(.N_SRC(N_SRC), .ROT_DIV(ROT_DIV)) u_rot (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (sample_stb),
      .cal_nxt (cal_nxt)
   );

   dac_seg_router #(.COARSE_W(COARSE_W)) u_route (
      .coarse  (coarse_c),
      .cal     (cal_nxt),
      .en      (en_c),
      .div_src (div_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_en  <= '0;
         cal_ptr <= '0;
         div_ptr <= PTR_W'(1);
         div_sw  <= '0;
      end else if (sample_stb) begin
         src_en  <= en_c;
         cal_ptr <= cal_nxt;
         div_ptr <= div_c;
         div_sw  <= fine_c;
      end
   end
endmodule

// File: rtl/dac_seg_checker.sv
// Property checker for dac_seg_decoder, attached through bind
module dac_seg_checker #(
   parameter int unsigned N_SRC  = 33,
   parameter int unsigned PTR_W  = 6,
   parameter int unsigned FINE_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sample_stb,
   input logic [N_SRC-1:0]  src_en,
   input logic [PTR_W-1:0]  cal_ptr,
   input logic [PTR_W-1:0]  div_ptr,
   input logic [FINE_W-1:0] div_sw
);
   // R6: the calibration slot never drives the output
   p_cal_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en & (N_SRC'(1) << cal_ptr)) == '0);

   // R6: divider is never fed by the source under calibration
   p_div_not_cal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      div_ptr != cal_ptr);

   // R5: divider source is not also enabled as a unit
   p_div_not_unit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_en & (N_SRC'(1) << div_ptr)) == '0);

   // R4: at most 31 unit sources can be on (one feeds the divider, one calibrates)
   p_unit_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(src_en) <= N_SRC - 2);

   // R8: pointers stay inside the source array
   p_ptr_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_ptr < PTR_W'(N_SRC)) && (div_ptr < PTR_W'(N_SRC)));

   // R7: without a strobe on the previous edge nothing moves
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(sample_stb) |-> ($stable(src_en) && $stable(cal_ptr)
                              && $stable(div_ptr) && $stable(div_sw)));

   // R8: the calibration slot only steps forward by one, wrapping at the end
   p_rotate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cal_ptr != $past(cal_ptr)) |->
         (cal_ptr == (($past(cal_ptr) == PTR_W'(N_SRC - 1)) ? '0
                                                              : $past(cal_ptr) + 1'b1)));
endmodule

bind dac_seg_decoder dac_seg_checker #(
   .N_SRC(N_SRC), .PTR_W(PTR_W), .FINE_W(FINE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sample_stb (sample_stb),
   .src_en     (src_en),
   .cal_ptr    (cal_ptr),
   .div_ptr    (div_ptr),
   .div_sw     (div_sw)
);

// File: tb/dac_seg_decoder_bench.sv
module dac_seg_decoder_bench;
   localparam int ROT = 64;
   localparam int NS  = 33;

   typedef struct packed {
      logic [32:0] en;
      logic [5:0]  cal;
      logic [5:0]  div;
      logic [10:0] fine;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stb = 1'b0;
   logic [15:0] code = '0;
   logic [32:0] src_en;
   logic [5:0]  cal_ptr, div_ptr;
   logic [10:0] div_sw;

   int   checks = 0;
   int   fails  = 0;
   exp_t q[$];
   string tq[$];
   exp_t last;
   bit   have_last = 0;
   logic stb_d = 1'b0;
   int   cal_m = 0;
   int   nstb  = 0;
   bit   done  = 0;

   always #5 clk = ~clk;

   dac_seg_decoder u_dac_seg_decoder (
      .clk(clk), .rst_n(rst_n), .sample_stb(stb), .sample_code(code),
      .src_en(src_en), .cal_ptr(cal_ptr), .div_ptr(div_ptr), .div_sw(div_sw)
   );

   task automatic chk(input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // expected outputs from the requirements
   function automatic exp_t model(input logic [15:0] c, input int cal);
      exp_t e;
      int u, k, pos;
      u = int'($signed(c)) + 32768 + 1024;
      if (u > 65535) u = 65535;          // R10 saturation
      k = u >> 11;
      e.fine = 11'(u & 2047);
      e.cal  = 6'(cal);
      e.en   = '0;
      pos = 0;
      e.div = '0;
      for (int s = 0; s < NS; s++) begin
         if (s != cal) begin
            if (pos < k) e.en[s] = 1'b1;
            if (pos == k) e.div = 6'(s);
            pos++;
         end
      end
      return e;
   endfunction

   task automatic send(input logic [15:0] c, input string tag, input int idle);
      exp_t e;
      @(negedge clk);
      nstb++;
      if (nstb % ROT == 0) cal_m = (cal_m == NS - 1) ? 0 : cal_m + 1;
      e = model(c, cal_m);
      q.push_back(e);
      tq.push_back(tag);
      code = c;
      stb  = 1'b1;
      @(negedge clk);
      stb  = 1'b0;
      code = c ^ 16'hA5C3;               // junk between strobes (R7)
      repeat (idle) @(negedge clk);
   endtask

   always @(posedge clk) stb_d <= stb;

   // monitor: compare on the negedge after each strobe edge, hold otherwise
   always @(negedge clk) begin
      if (rst_n && stb_d) begin
         if (q.size() == 0) begin
            chk("R7", "unexpected update", 1, 0);
         end else begin
            exp_t e;
            string t;
            e = q.pop_front();
            t = tq.pop_front();
            chk(t, "src_en", src_en, e.en);
            chk(t, "div_sw", div_sw, e.fine);
            chk(t, "div_ptr", div_ptr, e.div);
            chk(t, "cal_ptr", cal_ptr, e.cal);
            last = e;
            have_last = 1;
         end
      end else if (rst_n && have_last) begin
         chk("R7", "held src_en", src_en, last.en);
         chk("R7", "held div_sw", div_sw, last.fine);
         chk("R7", "held div_ptr", div_ptr, last.div);
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      repeat (3) @(negedge clk);
      // R1: reset values, inside reset and after release before any strobe
      chk("R1", "src_en", src_en, 0);
      chk("R1", "cal_ptr", cal_ptr, 0);
      chk("R1", "div_ptr", div_ptr, 1);
      chk("R1", "div_sw", div_sw, 0);
      rst_n = 1'b1;
      code  = 16'h7FFF;
      repeat (2) @(negedge clk);
      chk("R1", "src_en after release", src_en, 0);
      chk("R1", "div_ptr after release", div_ptr, 1);

      send(16'h0000, "R2", 2);
      send(16'hFFFF, "R3", 1);           // -1: only fine bits differ from 0
      send(16'h0000, "R3", 1);
      send(16'h03FF, "R3", 0);           // +1023
      send(16'hFC00, "R3", 0);           // -1024
      send(16'h0400, "R2", 1);           // +1024 -> k=17
      send(16'hFBFF, "R4", 1);           // -1025 -> k=15
      send(16'h8000, "R10", 2);          // most negative
      send(16'h7FFF, "R10", 1);          // saturates
      send(16'h7BFF, "R10", 0);          // +31743 last unsaturated
      send(16'h7C00, "R10", 0);          // +31744 first saturated
      send(16'h1234, "R5", 3);

      lfsr = 16'hACE1;
      for (int i = 0; i < 2200; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         send(lfsr, "R8 R9", i % 3);
      end
      send(16'h0000, "R8", 2);
      repeat (3) @(negedge clk);
      chk("R7", "queue drained", q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule